// File: doc/BRIEF.md
# Scoreboard Instruction Issue Controller

This block is the hazard bookkeeping for a machine with four execution units. Unit 0 handles integer work (loads, stores, ALU operations and branches). Unit 1 is a multiplier. Unit 2 is an adder that also does subtraction and conversion. Unit 3 is an unpipelined divider. Each cycle the block receives at most one decoded instruction. The instruction names its unit, an opcode, a destination register and two source registers. The block decides three things. It decides when the instruction may enter its unit. It decides when the unit may read its operands. It decides when the unit may write its result back. The unit datapaths and the decoder sit outside the block.

Each unit holds at most one instruction, and that instruction moves through four phases: idle, waiting for operands, executing, finished. For each register, a second table records which unit will produce its next value. Three hazards are each resolved at a different step:
- Output conflicts (WAW) and busy units are resolved when an instruction is accepted.
- True dependences (RAW) are resolved at the operand read.
- Anti-dependences (WAR) are resolved at the write-back.

The units report the end of execution with a one-cycle completion pulse.

Top module: `sb_issue_ctrl`

## Requirements
- R1: During and right after reset, every unit is idle and no register is pending. `in_ready` is 1 and `rd_grant` and `wr_grant` are 0.
- R2: An instruction is accepted in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 0 while the unit selected by `in_fu` holds an instruction. The unit encoding is 0 integer, 1 multiplier, 2 adder, 3 divider. A unit, the divider included, is freed only by its write grant. A sender whose instruction is refused keeps it on the inputs.
- R3: `in_ready` is 0 while any held instruction has `in_dst` as its destination.
- R4: Unit f gets a one-cycle `rd_grant[f]` pulse once both of its sources are ready. The earliest such cycle is the one after acceptance. A source is ready at acceptance when no held instruction targets it, or when its producer is granted its write in the acceptance cycle.
- R5: `fu_done[f]` is honoured only when unit f has had its read grant and has not yet completed. The earliest such cycle is the one after the read grant. In every other cycle the pulse is ignored.
- R6: A completed unit requests its write from the cycle after its completion pulse. The request is withheld while another unit is waiting for operands and holds a ready, unread source equal to that destination. This includes a unit that is being granted its read in the same cycle.
- R7: When several units request a write, the lowest-numbered one gets `wr_grant`, one unit per cycle. `wr_reg` and `wr_op` carry the granted unit's destination and opcode.
- R8: A write grant frees its unit and clears the register's pending entry, both effective in the next cycle. In the next cycle every unit waiting on that producer sees the source ready, so its read grant can come as early as that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is offered |
| in_fu | input | 2 | Target unit (0 int, 1 mul, 2 add, 3 div) |
| in_op | input | OP_W | Opcode, passed through to write-back |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| in_ready | output | 1 | The offered instruction may be accepted |
| fu_done | input | 4 | Per-unit completion pulse |
| rd_grant | output | 4 | Per-unit permission to read operands |
| wr_grant | output | 4 | One-hot permission to write a result |
| wr_reg | output | REG_W | Destination of the granted write (0 when none) |
| wr_op | output | OP_W | Opcode of the granted write (0 when none) |

## Verification
The hardest case to reach from the ports is the write-back stall. It needs a unit that has finished and wants to overwrite a register, while an older instruction in another unit still holds that register's old value as a ready source but cannot read yet. That older instruction cannot read because its other source is still in flight.

The bench reaches this state directly. It first starts a long divide. Next it accepts an add that uses the divide result and the register in question. Then it accepts a multiply that overwrites that register, and it lets the multiply complete at once while the divide is held back. It checks that the multiply's write waits until the add has been granted its read.

Long random runs over a small register set then produce hazards of every kind. They also send completion pulses to units that are not executing, and they check every output against a behavioural model on every cycle.

// File: rtl/sb_pkg.sv
// Package: shared constants and the per-unit phase type for the scoreboard.
// Assumes a fixed set of four units, numbered 0 int, 1 mul, 2 add, 3 div.
package sb_pkg;
    localparam int NUM_FU = 4;
    localparam int FU_W   = 2;

    typedef enum logic [1:0] {
        FU_IDLE = 2'd0,
        FU_WAIT = 2'd1,
        FU_EXEC = 2'd2,
        FU_DONE = 2'd3
    } fu_state_e;
endpackage

// File: rtl/sb_fu_entry.sv
// Module: status entry for one unit. It holds the phase, opcode, destination,
// sources, producing units and source-ready flags of the instruction in that unit.
// Assumes: issue_en arrives only while idle, rd_gnt only while waiting with
// both sources ready, wr_gnt only while finished.
module sb_fu_entry
    import sb_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int OP_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_en,
    input  logic [REG_W-1:0] iss_dst,
    input  logic [REG_W-1:0] iss_src1,
    input  logic [REG_W-1:0] iss_src2,
    input  logic [OP_W-1:0]  iss_op,
    input  logic             iss_rdy1,
    input  logic             iss_rdy2,
    input  logic [FU_W-1:0]  iss_q1,
    input  logic [FU_W-1:0]  iss_q2,
    input  logic             rd_gnt,
    input  logic             done_in,
    input  logic             wr_gnt,
    input  logic             wr_valid,
    input  logic [FU_W-1:0]  wr_unit,
    output fu_state_e        state,
    output logic [REG_W-1:0] dst,
    output logic [REG_W-1:0] src1,
    output logic [REG_W-1:0] src2,
    output logic [OP_W-1:0]  op,
    output logic             rdy1,
    output logic             rdy2
);
    logic [FU_W-1:0] q1;
    logic [FU_W-1:0] q2;

    // Advance the phase, capture the fields and track the source-ready flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FU_IDLE;
            dst   <= '0;
            src1  <= '0;
            src2  <= '0;
            op    <= '0;
            rdy1  <= 1'b0;
            rdy2  <= 1'b0;
            q1    <= '0;
            q2    <= '0;
        end else begin
            case (state)
                FU_IDLE: begin
                    if (issue_en) begin
                        state <= FU_WAIT;
                        dst   <= iss_dst;
                        src1  <= iss_src1;
                        src2  <= iss_src2;
                        op    <= iss_op;
                        rdy1  <= iss_rdy1;
                        rdy2  <= iss_rdy2;
                        q1    <= iss_q1;
                        q2    <= iss_q2;
                    end
                end
                FU_WAIT: begin
                    if (rd_gnt) begin
                        state <= FU_EXEC;
                        rdy1  <= 1'b0;
                        rdy2  <= 1'b0;
                    end else begin
                        if (wr_valid && !rdy1 && (q1 == wr_unit)) rdy1 <= 1'b1;
                        if (wr_valid && !rdy2 && (q2 == wr_unit)) rdy2 <= 1'b1;
                    end
                end
                FU_EXEC: begin
                    if (done_in) state <= FU_DONE;
                end
                FU_DONE: begin
                    if (wr_gnt) state <= FU_IDLE;
                end
                default: state <= FU_IDLE;
            endcase
        end
    end

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gnt |=> !rd_gnt);

    // R8
    wr_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gnt |=> (state == FU_IDLE));

    // R5
    exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FU_EXEC && !done_in) |=> (state == FU_EXEC));
endmodule

// File: rtl/sb_reg_status.sv
// Module: register result-status table. For each register it records whether
// a held instruction will write it and which unit will do so.
// Assumes: a set never targets a register that is already pending.
module sb_reg_status
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic [FU_W-1:0]  set_unit,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_reg,
    input  logic [FU_W-1:0]  clr_unit,
    output logic [NUM_REGS-1:0] pend,
    output logic [FU_W-1:0]  owner [NUM_REGS]
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        // Mark a register at acceptance; release it when its owner writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[r]  <= 1'b0;
                owner[r] <= '0;
            end else if (set_en && (set_reg == REG_W'(r))) begin
                pend[r]  <= 1'b1;
                owner[r] <= set_unit;
            end else if (clr_en && (clr_reg == REG_W'(r)) && (owner[r] == clr_unit)) begin
                pend[r]  <= 1'b0;
            end
        end
    end

    // R8
    rs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && pend[clr_reg] && (owner[clr_reg] == clr_unit)
         && !(set_en && set_reg == clr_reg)) |=> !pend[$past(clr_reg)]);

    // R3
    set_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !pend[set_reg]);
endmodule

// File: rtl/sb_wr_arbiter.sv
// Module: fixed-priority arbiter for write-back. The lowest-numbered requester wins.
// Assumes: purely combinational; the caller registers nothing through it.
module sb_wr_arbiter #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign gnt[i]    = req[i] && !seen[i];
        assign seen[i+1] = seen[i] || req[i];
    end

    assign any = seen[N];

    // Encode the index of the winning requester.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Check the grant shape against the requests.
    always_comb begin
        // R7
        grant_onehot_chk: assert ($onehot0(gnt));
        // R7
        grant_req_chk: assert ((gnt & ~req) == '0);
    end
endmodule

// File: rtl/sb_issue_ctrl.sv
// Module: scoreboard issue controller (top). It accepts decoded instructions,
// grants operand reads and write-backs, and resolves the three hazards:
// busy unit and WAW at acceptance, RAW at read, WAR at write.
// Assumes: the sender holds a refused instruction, and a unit pulses
// fu_done once per instruction it executes.
module sb_issue_ctrl
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int OP_W     = 4,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FU_W-1:0]   in_fu,
    input  logic [OP_W-1:0]   in_op,
    input  logic [REG_W-1:0]  in_dst,
    input  logic [REG_W-1:0]  in_src1,
    input  logic [REG_W-1:0]  in_src2,
    output logic              in_ready,
    input  logic [NUM_FU-1:0] fu_done,
    output logic [NUM_FU-1:0] rd_grant,
    output logic [NUM_FU-1:0] wr_grant,
    output logic [REG_W-1:0]  wr_reg,
    output logic [OP_W-1:0]   wr_op
);
    fu_state_e          st    [NUM_FU];
    logic [REG_W-1:0]   e_dst [NUM_FU];
    logic [REG_W-1:0]   e_s1  [NUM_FU];
    logic [REG_W-1:0]   e_s2  [NUM_FU];
    logic [OP_W-1:0]    e_op  [NUM_FU];
    logic [NUM_FU-1:0]  e_r1;
    logic [NUM_FU-1:0]  e_r2;

    logic [NUM_REGS-1:0] pend;
    logic [FU_W-1:0]     owner [NUM_REGS];

    logic               issue;
    logic               iss_rdy1;
    logic               iss_rdy2;
    logic [NUM_FU-1:0]  war_block;
    logic [NUM_FU-1:0]  wr_req;
    logic               wr_valid;
    logic [FU_W-1:0]    wr_idx;

    // Acceptance: the target unit must be idle and the destination not pending.
    assign in_ready = (st[in_fu] == FU_IDLE) && !pend[in_dst];
    assign issue    = in_valid && in_ready;

    // A source is ready when it has no producer, or its producer writes now.
    assign iss_rdy1 = !pend[in_src1] || (wr_valid && (wr_idx == owner[in_src1]));
    assign iss_rdy2 = !pend[in_src2] || (wr_valid && (wr_idx == owner[in_src2]));

    for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
        sb_fu_entry #(
            .REG_W (REG_W),
            .OP_W  (OP_W)
        ) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .issue_en (issue && (in_fu == FU_W'(f))),
            .iss_dst  (in_dst),
            .iss_src1 (in_src1),
            .iss_src2 (in_src2),
            .iss_op   (in_op),
            .iss_rdy1 (iss_rdy1),
            .iss_rdy2 (iss_rdy2),
            .iss_q1   (owner[in_src1]),
            .iss_q2   (owner[in_src2]),
            .rd_gnt   (rd_grant[f]),
            .done_in  (fu_done[f]),
            .wr_gnt   (wr_grant[f]),
            .wr_valid (wr_valid),
            .wr_unit  (wr_idx),
            .state    (st[f]),
            .dst      (e_dst[f]),
            .src1     (e_s1[f]),
            .src2     (e_s2[f]),
            .op       (e_op[f]),
            .rdy1     (e_r1[f]),
            .rdy2     (e_r2[f])
        );

        // Operand read: the unit is waiting and both sources are ready.
        assign rd_grant[f] = (st[f] == FU_WAIT) && e_r1[f] && e_r2[f];
    end

    // WAR screen: another waiting unit still needs the old value of our destination.
    always_comb begin
        for (int f = 0; f < NUM_FU; f++) begin
            war_block[f] = 1'b0;
            for (int g = 0; g < NUM_FU; g++) begin
                if (g != f && st[g] == FU_WAIT
                    && (((e_s1[g] == e_dst[f]) && e_r1[g])
                     || ((e_s2[g] == e_dst[f]) && e_r2[g])))
                    war_block[f] = 1'b1;
            end
            wr_req[f] = (st[f] == FU_DONE) && !war_block[f];
        end
    end

    sb_wr_arbiter #(
        .N     (NUM_FU),
        .IDX_W (FU_W)
    ) u_arb (
        .req (wr_req),
        .gnt (wr_grant),
        .any (wr_valid),
        .idx (wr_idx)
    );

    // Present the destination and opcode of the granted write.
    assign wr_reg = wr_valid ? e_dst[wr_idx] : '0;
    assign wr_op  = wr_valid ? e_op[wr_idx]  : '0;

    sb_reg_status #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_rstat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (issue),
        .set_reg  (in_dst),
        .set_unit (in_fu),
        .clr_en   (wr_valid),
        .clr_reg  (wr_reg),
        .clr_unit (wr_idx),
        .pend     (pend),
        .owner    (owner)
    );

    // R2
    issue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (st[$past(in_fu)] == FU_WAIT));

    // R3
    issue_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> pend[$past(in_dst)]);

    // R6
    war_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !war_block[wr_idx]);
endmodule

// File: tb/tb_sb_issue_ctrl.sv
module tb_sb_issue_ctrl;
    localparam int NR  = 32;
    localparam int OPW = 4;
    localparam int NF  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic           in_valid = 1'b0;
    logic [1:0]     in_fu = '0;
    logic [OPW-1:0] in_op = '0;
    logic [4:0]     in_dst = '0;
    logic [4:0]     in_src1 = '0;
    logic [4:0]     in_src2 = '0;
    logic [NF-1:0]  fu_done = '0;
    logic           in_ready;
    logic [NF-1:0]  rd_grant;
    logic [NF-1:0]  wr_grant;
    logic [4:0]     wr_reg;
    logic [OPW-1:0] wr_op;

    sb_issue_ctrl #(.NUM_REGS(NR), .OP_W(OPW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fu(in_fu),
        .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .in_ready(in_ready), .fu_done(fu_done), .rd_grant(rd_grant),
        .wr_grant(wr_grant), .wr_reg(wr_reg), .wr_op(wr_op)
    );

    // Reference model: phase 0 idle, 1 waiting, 2 executing, 3 finished.
    int m_st[NF], m_dst[NF], m_s1[NF], m_s2[NF], m_op[NF];
    int m_r1[NF], m_r2[NF], m_q1[NF], m_q2[NF];
    int m_rs[NR];
    bit e_ready;
    bit [NF-1:0] e_rd, e_wr;
    int e_w;
    bit s_rdy;
    bit [NF-1:0] s_rd, s_wr;
    int checks = 0, errors = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic void model_reset();
        for (int f = 0; f < NF; f++) begin
            m_st[f] = 0; m_dst[f] = 0; m_s1[f] = 0; m_s2[f] = 0; m_op[f] = 0;
            m_r1[f] = 0; m_r2[f] = 0; m_q1[f] = -1; m_q2[f] = -1;
        end
        for (int r = 0; r < NR; r++) m_rs[r] = -1;
    endfunction

    function automatic void model_comb();
        bit blk;
        e_ready = (m_st[int'(in_fu)] == 0) && (m_rs[int'(in_dst)] < 0);
        e_w = -1;
        for (int f = 0; f < NF; f++) begin
            e_rd[f] = (m_st[f] == 1) && (m_r1[f] != 0) && (m_r2[f] != 0);
            blk = 1'b0;
            for (int g = 0; g < NF; g++)
                if (g != f && m_st[g] == 1 &&
                    ((m_s1[g] == m_dst[f] && m_r1[g] != 0) || (m_s2[g] == m_dst[f] && m_r2[g] != 0)))
                    blk = 1'b1;
            if (m_st[f] == 3 && !blk && e_w < 0) e_w = f;
        end
        e_wr = (e_w >= 0) ? NF'(1 << e_w) : '0;
    endfunction

    function automatic void model_step();
        int p1, p2, u;
        bit acc;
        acc = in_valid && e_ready;
        p1 = m_rs[int'(in_src1)];
        p2 = m_rs[int'(in_src2)];
        for (int f = 0; f < NF; f++)
            if (m_st[f] == 2 && fu_done[f]) m_st[f] = 3;
        for (int f = 0; f < NF; f++)
            if (e_rd[f]) begin m_st[f] = 2; m_r1[f] = 0; m_r2[f] = 0; end
        if (e_w >= 0) begin
            m_st[e_w] = 0;
            if (m_rs[m_dst[e_w]] == e_w) m_rs[m_dst[e_w]] = -1;
            for (int g = 0; g < NF; g++)
                if (m_st[g] == 1) begin
                    if (m_r1[g] == 0 && m_q1[g] == e_w) m_r1[g] = 1;
                    if (m_r2[g] == 0 && m_q2[g] == e_w) m_r2[g] = 1;
                end
        end
        if (acc) begin
            u = int'(in_fu);
            m_st[u] = 1; m_dst[u] = int'(in_dst); m_op[u] = int'(in_op);
            m_s1[u] = int'(in_src1); m_s2[u] = int'(in_src2);
            m_q1[u] = p1; m_q2[u] = p2;
            m_r1[u] = (p1 < 0 || p1 == e_w) ? 1 : 0;
            m_r2[u] = (p2 < 0 || p2 == e_w) ? 1 : 0;
            m_rs[int'(in_dst)] = u;
        end
    endfunction

    // One clock: compare all outputs, then advance the model.
    task automatic cycle();
        #1;
        model_comb();
        s_rdy = in_ready; s_rd = rd_grant; s_wr = wr_grant;
        chk(in_ready === e_ready, (m_rs[int'(in_dst)] >= 0) ? "R3" : "R2", "in_ready",
            int'(in_ready), int'(e_ready));
        chk(rd_grant === e_rd, "R4", "rd_grant", int'(rd_grant), int'(e_rd));
        chk(wr_grant === e_wr, "R6", "wr_grant", int'(wr_grant), int'(e_wr));
        if (e_w >= 0) begin
            chk(int'(wr_reg) == m_dst[e_w], "R7", "wr_reg", int'(wr_reg), m_dst[e_w]);
            chk(int'(wr_op) == m_op[e_w], "R7", "wr_op", int'(wr_op), m_op[e_w]);
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
        cyc++;
    endtask

    task automatic put(input int fu, input int dst, input int a, input int b);
        in_valid = 1'b1; in_fu = 2'(fu); in_dst = 5'(dst);
        in_src1 = 5'(a); in_src2 = 5'(b); in_op = OPW'(fu + dst);
    endtask

    task automatic drain();
        bit busy;
        in_valid = 1'b0; fu_done = '1;
        for (int k = 0; k < 40; k++) begin
            busy = 1'b0;
            for (int f = 0; f < NF; f++) if (m_st[f] != 0) busy = 1'b1;
            if (busy) cycle();
        end
        fu_done = '0;
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int mul_wr, add_rd;
        bit cur_v;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(in_ready === 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        chk(rd_grant === '0, "R1", "rd_grant in reset", int'(rd_grant), 0);
        chk(wr_grant === '0, "R1", "wr_grant in reset", int'(wr_grant), 0);
        rst_n = 1'b1;
        cycle();
        chk(s_rdy && s_rd == 0 && s_wr == 0, "R1", "idle after reset", int'(s_rdy), 1);

        // R5: completion pulses to idle units are ignored
        fu_done = '1; cycle();
        put(0, 1, 2, 3); cycle();
        in_valid = 1'b0; fu_done = 4'b1110; cycle();
        chk(s_rd == 4'b0001, "R4", "int read next cycle", int'(s_rd), 1);
        for (int k = 0; k < 3; k++) begin
            cycle();
            chk(s_wr == 0, "R5", "no write without honoured done", int'(s_wr), 0);
        end
        fu_done = 4'b0001; cycle();
        fu_done = '0; put(0, 5, 2, 3); cycle();
        chk(s_wr == 4'b0001, "R6", "write after done", int'(s_wr), 1);
        chk(!s_rdy, "R8", "unit still held on grant cycle", int'(s_rdy), 0);
        cycle();
        chk(s_rdy, "R8", "unit free after write", int'(s_rdy), 1);
        put(1, 5, 6, 7); cycle();
        chk(!s_rdy, "R3", "WAW blocks same destination", int'(s_rdy), 0);
        drain();

        // R6: WAR stall of a completed multiply behind a waiting add
        put(3, 0, 1, 2); cycle();
        put(2, 10, 0, 8); cycle();
        put(1, 8, 8, 14); cycle();
        in_valid = 1'b0; fu_done = 4'b0010;
        mul_wr = -1; add_rd = -1;
        for (int k = 0; k < 10; k++) begin
            cycle();
            if (s_wr[1] && mul_wr < 0) mul_wr = cyc;
        end
        chk(mul_wr < 0, "R6", "multiply write held by WAR", mul_wr, -1);
        fu_done = 4'b1110;
        for (int k = 0; k < 30; k++) begin
            cycle();
            if (s_rd[2] && add_rd < 0) add_rd = cyc;
            if (s_wr[1] && mul_wr < 0) mul_wr = cyc;
        end
        chk(add_rd > 0 && mul_wr > add_rd, "R6", "multiply writes after add reads", mul_wr, add_rd + 1);
        drain();

        // R7: three simultaneous requests granted lowest first
        fu_done = '0;
        put(0, 1, 20, 21); cycle();
        put(1, 2, 20, 21); cycle();
        put(2, 3, 20, 21); cycle();
        in_valid = 1'b0; cycle();
        fu_done = 4'b0111; cycle();
        fu_done = '0;
        cycle(); chk(s_wr == 4'b0001, "R7", "first grant", int'(s_wr), 1);
        cycle(); chk(s_wr == 4'b0010, "R7", "second grant", int'(s_wr), 2);
        cycle(); chk(s_wr == 4'b0100, "R7", "third grant", int'(s_wr), 4);
        drain();

        // Random traffic over a small register set
        cur_v = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            if (!cur_v) begin
                put($urandom % 4, $urandom % 8, $urandom % 8, $urandom % 8);
                in_op = OPW'($urandom);
                in_valid = ($urandom % 5) != 0;
                cur_v = in_valid;
            end
            for (int f = 0; f < NF; f++)
                fu_done[f] = (m_st[f] == 2) ? (($urandom % ((f == 3) ? 6 : 2)) == 0)
                                           : (($urandom % 8) == 0);
            cycle();
            if (in_valid && s_rdy) begin cur_v = 1'b0; in_valid = 1'b0; end
        end
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule